// File: doc/BRIEF.md
# Masked Hit Sub-Region Sequencer

This block watches one row of pixel hit lines and turns the hits of each bunch crossing into compact records for a small local buffer. A serially loaded enable mask decides which pixels can register a hit. Enabled hits are held in sticky latches until a crossing strobe arrives. The strobe then takes a snapshot of the latches and of the timestamp bus, and the block steps a group address through every pixel group, one group per clock.

Each group that holds at least one enabled hit produces one record. A record contains the group address, the group's hit pattern and the timestamp taken at the strobe. The record goes out with a one-hot write enable for the next free buffer slot. Address 0 is a null code: it never selects pixels and never writes, so the address field of a record is never zero. When the buffer is full, further records are dropped and a sticky overflow flag is raised. An init pulse clears the latches, the slot pointer, the flag and any scan in progress, and it leaves the mask as it is.

Top module: `hit_subregion_seq`

## Requirements
- R1: The mask loads one bit per clock while `mask_shift` is high. The first bit shifted in ends up at pixel 35 after 36 shifts. A mask bit of 1 enables its pixel. A hit on a pixel whose mask bit is 0 never shows up in any record.
- R2: Group address a (1..6) covers pixels 6(a-1) to 6(a-1)+5. Bit j of the record's pattern field is pixel 6(a-1)+j. The record is {addr[21:19], pattern[18:13], timestamp[12:0]}.
- R3: `bx_strobe` is sampled at an idle clock edge E. The record for address a then appears after edge E+a. Addresses are visited in ascending order, and only groups with at least one enabled hit produce a record.
- R4: Address 0 never produces a write. While no write enable is high, `wr_data` reads zero.
- R5: Every record of a scan carries the `ts_in` value sampled at the edge that accepted the strobe.
- R6: An enabled hit is held from the cycle it is seen until the next accepted strobe. A hit present on the strobe cycle itself joins that scan. The latches are empty after the snapshot.
- R7: A strobe that arrives while a scan is running is ignored. Hits from that cycle stay latched and go with the next accepted strobe.
- R8: At most one write enable is high at a time. Since the last init, the n-th record written (counting from 0) goes to slot n.
- R9: Once all DEPTH slots are written, further records are dropped. In the cycle the first record is dropped, `overflow` rises, and it stays high until init.
- R10: `init` clears the hit latches, the slot pointer, `overflow` and any scan in progress. The cycle after init shows no write and `overflow` low.
- R11: After reset the mask is all zeros, so no pixel is enabled, and all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init | input | 1 | Clears latches, pointer, flag and scan |
| mask_sdi | input | 1 | Serial mask data |
| mask_shift | input | 1 | Shift enable for the mask register |
| hit_in | input | 36 | Pixel hit lines |
| bx_strobe | input | 1 | End-of-crossing strobe that starts a scan |
| ts_in | input | 13 | Bunch-crossing timestamp |
| wr_data | output | 22 | Record to write |
| wr_en | output | 8 | One-hot per-slot write enable |
| overflow | output | 1 | Sticky flag for a dropped record |

## Verification
Two events can fall in the same cycle: a new hit being latched and the strobe taking the snapshot. The bench drives a hit in exactly the strobe cycle and expects that hit in the current scan with the current timestamp. It also drives a second strobe in the middle of a scan together with a fresh hit, and expects that hit only in the next scan, carrying the next timestamp. A second pair is a record that arrives in the same cycle the buffer becomes full. Here the scoreboard expects the last two slots to be written, the remaining records to be absent, and `overflow` to be high afterwards.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int DEF_GROUPS = 6;
  localparam int DEF_GROUP_W = 6;
  localparam int DEF_ADDR_W = 3;
  localparam int DEF_TS_W = 13;
  localparam int DEF_DEPTH = 8;

  function automatic int rec_width(int addr_w, int group_w, int ts_w);
    return addr_w + group_w + ts_w;
  endfunction
endpackage

// File: rtl/mask_shreg.sv
module mask_shreg #(
  parameter int NPIX = 36
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            shift,
  input  logic            sdi,
  output logic [NPIX-1:0] mask
);
  always_ff @(posedge clk) begin
    if (rst) mask <= '0;
    else if (shift) mask <= {mask[NPIX-2:0], sdi};
  end
endmodule

// File: rtl/hit_capture.sv
module hit_capture #(
  parameter int NPIX = 36
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            init,
  input  logic [NPIX-1:0] hit_in,
  input  logic [NPIX-1:0] mask,
  input  logic            take,
  output logic [NPIX-1:0] snap
);
  logic [NPIX-1:0] held;
  logic [NPIX-1:0] hit_ok;

  assign hit_ok = hit_in & mask;

  always_ff @(posedge clk) begin
    if (rst || init) begin
      held <= '0;
      snap <= '0;
    end else if (take) begin
      snap <= held | hit_ok;
      held <= '0;
    end else begin
      held <= held | hit_ok;
    end
  end
endmodule

// File: rtl/group_mux.sv
module group_mux #(
  parameter int N_GROUPS = 6,
  parameter int GROUP_W = 6,
  parameter int ADDR_W = 3
) (
  input  logic [ADDR_W-1:0]           addr,
  input  logic [N_GROUPS*GROUP_W-1:0] snap,
  output logic [GROUP_W-1:0]          pattern,
  output logic                        valid
);
  logic [GROUP_W-1:0] grp_pat [N_GROUPS];
  logic [N_GROUPS-1:0] grp_sel;

  for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
    assign grp_pat[g] = snap[g*GROUP_W +: GROUP_W];
    assign grp_sel[g] = (addr == ADDR_W'(g + 1));
  end

  always_comb begin
    pattern = '0;
    for (int g = 0; g < N_GROUPS; g++) begin
      if (grp_sel[g]) pattern = grp_pat[g];
    end
  end

  assign valid = |pattern;
endmodule

// File: rtl/write_ctrl.sv
module write_ctrl #(
  parameter int DEPTH = 8,
  parameter int REC_W = 22
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             init,
  input  logic             rec_valid,
  input  logic [REC_W-1:0] rec_data,
  output logic [REC_W-1:0] wr_data,
  output logic [DEPTH-1:0] wr_en,
  output logic             overflow
);
  localparam int PTR_W = $clog2(DEPTH + 1);

  logic [PTR_W-1:0] ptr;
  logic             full;
  logic [DEPTH-1:0] slot_oh;

  assign full = (ptr == PTR_W'(DEPTH));

  always_comb begin
    slot_oh = '0;
    for (int s = 0; s < DEPTH; s++) begin
      if (ptr == PTR_W'(s)) slot_oh[s] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || init) begin
      ptr      <= '0;
      wr_en    <= '0;
      wr_data  <= '0;
      overflow <= 1'b0;
    end else begin
      wr_en   <= '0;
      wr_data <= '0;
      if (rec_valid) begin
        if (!full) begin
          wr_en   <= slot_oh;
          wr_data <= rec_data;
          ptr     <= ptr + 1'b1;
        end else begin
          overflow <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/hit_subregion_seq.sv
module hit_subregion_seq
  import seq_pkg::*;
#(
  parameter int N_GROUPS = DEF_GROUPS,
  parameter int GROUP_W = DEF_GROUP_W,
  parameter int ADDR_W = DEF_ADDR_W,
  parameter int TS_W = DEF_TS_W,
  parameter int DEPTH = DEF_DEPTH
) (
  input  logic                                    clk,
  input  logic                                    rst,
  input  logic                                    init,
  input  logic                                    mask_sdi,
  input  logic                                    mask_shift,
  input  logic [N_GROUPS*GROUP_W-1:0]             hit_in,
  input  logic                                    bx_strobe,
  input  logic [TS_W-1:0]                         ts_in,
  output logic [ADDR_W+GROUP_W+TS_W-1:0]          wr_data,
  output logic [DEPTH-1:0]                        wr_en,
  output logic                                    overflow
);
  localparam int NPIX = N_GROUPS * GROUP_W;
  localparam int REC_W = rec_width(ADDR_W, GROUP_W, TS_W);

  logic [NPIX-1:0]    mask;
  logic [NPIX-1:0]    snap;
  logic [ADDR_W-1:0]  scan_addr;
  logic [TS_W-1:0]    ts_q;
  logic               take;
  logic [GROUP_W-1:0] pattern;
  logic               rec_valid;
  logic [REC_W-1:0]   rec_data;

  assign take = bx_strobe && (scan_addr == '0) && !init;

  always_ff @(posedge clk) begin
    if (rst || init) begin
      scan_addr <= '0;
      ts_q      <= '0;
    end else if (scan_addr == '0) begin
      if (bx_strobe) begin
        scan_addr <= ADDR_W'(1);
        ts_q      <= ts_in;
      end
    end else if (scan_addr == ADDR_W'(N_GROUPS)) begin
      scan_addr <= '0;
    end else begin
      scan_addr <= scan_addr + 1'b1;
    end
  end

  mask_shreg #(.NPIX(NPIX)) u_mask (
    .clk(clk), .rst(rst), .shift(mask_shift), .sdi(mask_sdi), .mask(mask)
  );

  hit_capture #(.NPIX(NPIX)) u_cap (
    .clk(clk), .rst(rst), .init(init), .hit_in(hit_in), .mask(mask),
    .take(take), .snap(snap)
  );

  group_mux #(.N_GROUPS(N_GROUPS), .GROUP_W(GROUP_W), .ADDR_W(ADDR_W)) u_mux (
    .addr(scan_addr), .snap(snap), .pattern(pattern), .valid(rec_valid)
  );

  assign rec_data = {scan_addr, pattern, ts_q};

  write_ctrl #(.DEPTH(DEPTH), .REC_W(REC_W)) u_wr (
    .clk(clk), .rst(rst), .init(init), .rec_valid(rec_valid),
    .rec_data(rec_data), .wr_data(wr_data), .wr_en(wr_en), .overflow(overflow)
  );
endmodule

// File: rtl/seq_checker.sv
module seq_checker #(
  parameter int N_GROUPS = 6,
  parameter int GROUP_W = 6,
  parameter int ADDR_W = 3,
  parameter int TS_W = 13,
  parameter int DEPTH = 8
) (
  input logic                             clk,
  input logic                             rst,
  input logic                             init,
  input logic [ADDR_W+GROUP_W+TS_W-1:0]   wr_data,
  input logic [DEPTH-1:0]                 wr_en,
  input logic                             overflow
);
  localparam int REC_W = ADDR_W + GROUP_W + TS_W;

  logic [ADDR_W-1:0]  f_addr;
  logic [GROUP_W-1:0] f_pat;

  assign f_addr = wr_data[REC_W-1 -: ADDR_W];
  assign f_pat  = wr_data[TS_W +: GROUP_W];

  assert_onehot_slot_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_en));

  assert_idle_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en == '0) |-> (wr_data == '0));

  assert_real_group_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en != '0) |-> (f_pat != '0 && f_addr != '0 && f_addr <= ADDR_W'(N_GROUPS)));

  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (overflow && !init) |=> overflow);

  assert_init_clears_R10: assert property (@(posedge clk) disable iff (rst)
    init |=> (wr_en == '0 && !overflow));

  assert_ascending_R3: assert property (@(posedge clk) disable iff (rst)
    ((wr_en != '0) && ($past(wr_en) != '0)) |->
      (f_addr > $past(wr_data[REC_W-1 -: ADDR_W])));
endmodule

bind hit_subregion_seq seq_checker #(
  .N_GROUPS(N_GROUPS), .GROUP_W(GROUP_W), .ADDR_W(ADDR_W), .TS_W(TS_W), .DEPTH(DEPTH)
) u_chk (
  .clk(clk), .rst(rst), .init(init), .wr_data(wr_data), .wr_en(wr_en), .overflow(overflow)
);

// File: tb/tb_hit_subregion_seq.sv
module tb_hit_subregion_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NG = 6, GW = 6, AW = 3, TW = 13, DEPTH = 8;
  localparam int NPIX = NG * GW;
  localparam int RW = AW + GW + TW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic init = 1'b0;
  logic mask_sdi = 1'b0;
  logic mask_shift = 1'b0;
  logic [NPIX-1:0] hit_in = '0;
  logic bx_strobe = 1'b0;
  logic [TW-1:0] ts_in = '0;
  logic [RW-1:0] wr_data;
  logic [DEPTH-1:0] wr_en;
  logic overflow;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  typedef struct {
    int slot;
    logic [RW-1:0] data;
    int when;
  } exp_t;
  exp_t q[$];

  logic [NPIX-1:0] m_mask = '0;
  logic [NPIX-1:0] m_held = '0;
  int m_slot = 0;
  int m_busy_until = -1;
  bit m_ovf = 1'b0;

  hit_subregion_seq dut (
    .clk(clk), .rst(rst), .init(init), .mask_sdi(mask_sdi), .mask_shift(mask_shift),
    .hit_in(hit_in), .bx_strobe(bx_strobe), .ts_in(ts_in),
    .wr_data(wr_data), .wr_en(wr_en), .overflow(overflow)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // driver: one cycle of stimulus, model updated, expected records queued
  task automatic step(input logic [NPIX-1:0] hits, input bit strb, input logic [TW-1:0] ts);
    int e;
    @(negedge clk);
    hit_in = hits;
    bx_strobe = strb;
    ts_in = ts;
    e = cyc + 1;
    if (strb && e > m_busy_until) begin
      logic [NPIX-1:0] s;
      s = m_held | (hits & m_mask);
      m_held = '0;
      m_busy_until = e + NG;
      for (int a = 1; a <= NG; a++) begin
        logic [GW-1:0] p;
        p = s[(a-1)*GW +: GW];
        if (p != '0) begin
          if (m_slot < DEPTH) begin
            exp_t x;
            x.slot = m_slot;
            x.data = {AW'(a), p, ts};
            x.when = e + a;
            q.push_back(x);
            m_slot++;
          end else begin
            m_ovf = 1'b1;
          end
        end
      end
    end else begin
      m_held = m_held | (hits & m_mask);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step('0, 1'b0, '0);
  endtask

  task automatic load_mask(input logic [NPIX-1:0] m);
    for (int i = NPIX - 1; i >= 0; i--) begin
      @(negedge clk);
      mask_shift = 1'b1;
      mask_sdi = m[i];
    end
    @(negedge clk);
    mask_shift = 1'b0;
    m_mask = m;
  endtask

  task automatic do_init();
    @(negedge clk);
    hit_in = '0;
    bx_strobe = 1'b0;
    init = 1'b1;
    m_held = '0;
    m_slot = 0;
    m_ovf = 1'b0;
    m_busy_until = -1;
    @(negedge clk);
    init = 1'b0;
  endtask

  // monitor: pops the scoreboard whenever a write appears
  always @(negedge clk) begin
    if (!rst) begin
      if (wr_en != '0) begin
        if (q.size() == 0) begin
          chk(1'b0, "R1", "unexpected write", 64'(wr_data), 64'h0);
        end else begin
          exp_t x;
          logic [DEPTH-1:0] oh;
          x = q.pop_front();
          oh = '0;
          oh[x.slot] = 1'b1;
          chk(wr_en == oh, "R8", "slot enable", 64'(wr_en), 64'(oh));
          chk(wr_data[RW-1:TW] == x.data[RW-1:TW], "R2", "addr/pattern",
              64'(wr_data[RW-1:TW]), 64'(x.data[RW-1:TW]));
          chk(wr_data[TW-1:0] == x.data[TW-1:0], "R5", "timestamp",
              64'(wr_data[TW-1:0]), 64'(x.data[TW-1:0]));
          chk(cyc == x.when, "R3", "write cycle", 64'(cyc), 64'(x.when));
        end
      end else if (wr_data != '0) begin
        chk(1'b0, "R4", "idle data", 64'(wr_data), 64'h0);
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(wr_en == '0 && wr_data == '0 && overflow == 1'b0, "R11", "reset outputs",
        64'({overflow, wr_en, wr_data}), 64'h0);
    rst = 1'b0;

    // R11: unloaded mask blocks every pixel
    step('1, 1'b1, 13'h0001);
    idle(10);

    // R1: mask with group 2 (pixels 6..11) disabled
    load_mask(36'hFFFFFF03F);

    // R2 R3 R5: two groups hit in one crossing
    step(36'h000_0C0_000, 1'b0, '0);
    step(36'h000_000_001, 1'b1, 13'h008E);
    idle(10);

    // R1: hits only on masked pixels, no record expected
    step(36'h000_000_FC0, 1'b1, 13'h0050);
    idle(10);

    // R6: hit latched earlier plus hit on the strobe cycle itself
    step(36'h000_000_020, 1'b0, '0);
    idle(2);
    step(36'h080_000_000, 1'b1, 13'h008F);
    idle(10);

    // R7: second strobe during scan is ignored, its hit waits
    step(36'h000_040_000, 1'b1, 13'h0100);
    idle(2);
    step(36'h800_000_000, 1'b1, 13'h0101);
    idle(10);
    step('0, 1'b1, 13'h0102);
    idle(10);
    chk(overflow == 1'b0, "R9", "no overflow before full", 64'(overflow), 64'h0);

    // R9: all pixels hit, buffer fills and records are dropped
    step('1, 1'b1, 13'h0200);
    idle(10);
    chk(overflow == m_ovf, "R9", "overflow after full", 64'(overflow), 64'(m_ovf));
    chk(m_ovf == 1'b1, "R9", "model expects overflow", 64'(m_ovf), 64'h1);

    // R10: init clears flag, pointer and latches
    step(36'h000_000_004, 1'b0, '0);
    do_init();
    chk(overflow == 1'b0, "R10", "overflow after init", 64'(overflow), 64'h0);
    step('0, 1'b1, 13'h0300);
    idle(10);
    step(36'h001_000_000, 1'b1, 13'h0301);
    idle(10);

    chk(q.size() == 0, "R3", "pending records", 64'(q.size()), 64'h0);
    finish_run();
  end
endmodule